// File: doc/BRIEF.md
# Conversion Result Threshold Filter

This block watches the stream of results from an analog-to-digital converter and decides, over many conversions, whether a measured quantity has stayed on one side of a programmable threshold. Each valid result is compared against the threshold. A true compare steps a filter counter up. A false compare either steps it down or clears it, as selected in the control register. When the counter lands on a programmed target count, a sticky comparator flag is raised. Short excursions of a current, voltage or position therefore do not raise an event, and a sustained condition does.

The comparison is unsigned by default. It becomes two's complement only for ratiometric conversions that report a signed result. While the comparator is enabled, the per-conversion ready flag from the converter is blocked, so that only filtered events reach the interrupt logic downstream. Software reaches the block through a small byte-wide register port. The threshold and control registers cannot be written while a conversion is in flight.

Top module: `conv_threshold_filter`

## Requirements
- R1: After reset every register reads 0x00 and `cmp_flag_o` is 0.
- R2: Address 0 holds threshold bits 7:0. Address 1 holds enable in bit 7, compare mode in bit 6, decrement-select in bit 5 and threshold bits 9:8 in bits 1:0; its bits 4:2 always read 0. Address 2 holds the 8-bit target count. Address 3 reads the comparator flag in bit 0.
- R3: While `conv_busy_i` is 1, writes to addresses 0 and 1 are dropped, and writes to address 2 still take effect.
- R4: With mode 0, a compare is true when result >= threshold. With mode 1, it is true when result < threshold.
- R5: The compare is two's complement when `conv_kind_i` is 1 (ratiometric) and `res_sign_i` is 1. It is unsigned for kind 0 (absolute), kind 2 (temperature), kind 3, and for ratiometric with sign 0.
- R6: On each valid result with the comparator enabled, a true compare adds one to the counter, saturating at 255. With no valid result the counter holds.
- R7: On a false compare, the counter drops by one (not below 0) when decrement-select is 1, and clears to 0 when it is 0.
- R8: When the updated count equals a nonzero target, the flag is set and the counter restarts from 0 on the same edge. A target of 0 never fires.
- R9: The flag stays set until a write to address 3 with bit 0 = 1. If a new event and that clear arrive on the same edge, the flag stays set.
- R10: While disabled, the counter is held at 0 and valid results raise no flag.
- R11: `ready_irq_o` equals `conv_done_flag_i` while the comparator is disabled and is 0 while it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for `cfg_addr_i` (combinational) |
| conv_busy_i | input | 1 | A conversion is running; locks threshold and control |
| conv_kind_i | input | 2 | Conversion type: 0 absolute, 1 ratiometric, 2 temperature |
| res_sign_i | input | 1 | Ratiometric result is signed |
| res_valid_i | input | 1 | One-cycle strobe: `res_data_i` holds a new result |
| res_data_i | input | RES_W | Conversion result |
| conv_done_flag_i | input | 1 | Per-conversion ready flag from the converter |
| ready_irq_o | output | 1 | Ready flag after masking |
| cmp_flag_o | output | 1 | Sticky comparator event flag |

## Verification
The bench builds the block with its default widths: a 10-bit result and an 8-bit counter. With these widths every one of the 1024 result codes can be swept against thresholds on both sides of the signed midpoint, in both compare modes and for every combination of conversion kind and sign. A target of 1 turns each compare outcome directly into a flag value. Long pseudo-random result streams with a target of 5 exercise both false-compare policies. A run of 300 true compares with the target at 0 drives the 8-bit counter into saturation, and a later lowered target shows that the counter held at 255 rather than wrapping.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
  localparam logic [1:0] REG_THR_LO = 2'd0;
  localparam logic [1:0] REG_CTRL   = 2'd1;
  localparam logic [1:0] REG_TARGET = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_BIT = 6;
  localparam int CTRL_DEC_BIT  = 5;

  typedef enum logic [1:0] {
    KIND_ABS   = 2'd0,
    KIND_RATIO = 2'd1,
    KIND_TEMP  = 2'd2,
    KIND_RSVD  = 2'd3
  } conv_kind_e;
endpackage

// File: rtl/ctf_rst_sync.sv
module ctf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ctf_regs.sv
module ctf_regs #(
  parameter int RES_W = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             conv_busy,
  input  logic             flag,
  output logic [7:0]       rdata,
  output logic             en,
  output logic             mode,
  output logic             dec,
  output logic [RES_W-1:0] thr,
  output logic [CNT_W-1:0] target,
  output logic             flag_clr
);
  import ctf_pkg::*;
  localparam int HI_W = RES_W - 8;

  logic [7:0]       lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             en_q, en_d, mode_q, mode_d, dec_q, dec_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             ld;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    en_d   = en_q;
    mode_d = mode_q;
    dec_d  = dec_q;
    tgt_d  = tgt_q;
    ld     = 1'b0;
    if (we) begin
      case (addr)
        REG_THR_LO: if (!conv_busy) begin
          lo_d = wdata;
          ld   = 1'b1;
        end
        REG_CTRL: if (!conv_busy) begin
          en_d   = wdata[CTRL_EN_BIT];
          mode_d = wdata[CTRL_MODE_BIT];
          dec_d  = wdata[CTRL_DEC_BIT];
          hi_d   = wdata[HI_W-1:0];
          ld     = 1'b1;
        end
        REG_TARGET: begin
          tgt_d = wdata[CNT_W-1:0];
          ld    = 1'b1;
        end
        default: ld = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      dec_q  <= 1'b0;
      tgt_q  <= '0;
    end else if (ld) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      dec_q  <= dec_d;
      tgt_q  <= tgt_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      REG_THR_LO: rdata = lo_q;
      REG_CTRL: begin
        rdata[CTRL_EN_BIT]   = en_q;
        rdata[CTRL_MODE_BIT] = mode_q;
        rdata[CTRL_DEC_BIT]  = dec_q;
        rdata[HI_W-1:0]      = hi_q;
      end
      REG_TARGET: rdata[CNT_W-1:0] = tgt_q;
      default:    rdata[0] = flag;
    endcase
  end

  assign flag_clr = we && (addr == REG_STATUS) && wdata[0];
  assign en       = en_q;
  assign mode     = mode_q;
  assign dec      = dec_q;
  assign thr      = {hi_q, lo_q};
  assign target   = tgt_q;
endmodule

// File: rtl/ctf_compare.sv
module ctf_compare #(
  parameter int RES_W = 10
) (
  input  logic [RES_W-1:0] res,
  input  logic [RES_W-1:0] thr,
  input  logic             mode,
  input  logic [1:0]       kind,
  input  logic             sign,
  output logic             hit
);
  import ctf_pkg::*;

  logic             signed_sel;
  logic [RES_W-1:0] bias, res_b, thr_b;
  logic             at_or_above;

  // Flipping the top bit maps two's complement order onto unsigned order.
  assign signed_sel  = (kind == KIND_RATIO) && sign;
  assign bias        = {signed_sel, {(RES_W-1){1'b0}}};
  assign res_b       = res ^ bias;
  assign thr_b       = thr ^ bias;
  assign at_or_above = (res_b >= thr_b);
  assign hit         = mode ? !at_or_above : at_or_above;
endmodule

// File: rtl/ctf_counter.sv
module ctf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             valid,
  input  logic             hit,
  input  logic             dec,
  input  logic [CNT_W-1:0] target,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             flag_q, flag_d, fire;

  always_comb begin
    step = cnt_q;
    if (hit)      step = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    else if (dec) step = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    else          step = '0;
  end

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!en) begin
      cnt_d = '0;
    end else if (valid) begin
      if ((target != '0) && (step == target)) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = step;
      end
    end
    flag_d = fire ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/conv_threshold_filter.sv
module conv_threshold_filter #(
  parameter int RES_W = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             conv_busy_i,
  input  logic [1:0]       conv_kind_i,
  input  logic             res_sign_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic             conv_done_flag_i,
  output logic             ready_irq_o,
  output logic             cmp_flag_o
);
  logic             rst_sn;
  logic             cmp_en, cmp_mode, cmp_dec, flag_clr, hit;
  logic [RES_W-1:0] thr;
  logic [CNT_W-1:0] target, cnt;

  ctf_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ctf_regs #(.RES_W(RES_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .we        (cfg_we_i),
    .addr      (cfg_addr_i),
    .wdata     (cfg_wdata_i),
    .conv_busy (conv_busy_i),
    .flag      (cmp_flag_o),
    .rdata     (cfg_rdata_o),
    .en        (cmp_en),
    .mode      (cmp_mode),
    .dec       (cmp_dec),
    .thr       (thr),
    .target    (target),
    .flag_clr  (flag_clr)
  );

  ctf_compare #(.RES_W(RES_W)) u_cmp (
    .res  (res_data_i),
    .thr  (thr),
    .mode (cmp_mode),
    .kind (conv_kind_i),
    .sign (res_sign_i),
    .hit  (hit)
  );

  ctf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (cmp_en),
    .valid    (res_valid_i),
    .hit      (hit),
    .dec      (cmp_dec),
    .target   (target),
    .flag_clr (flag_clr),
    .cnt      (cnt),
    .flag     (cmp_flag_o)
  );

  assign ready_irq_o = conv_done_flag_i && !cmp_en;
endmodule

// File: rtl/ctf_checker.sv
module ctf_checker #(
  parameter int RES_W = 10,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_addr_i,
  input logic [7:0]       cfg_rdata_o,
  input logic             conv_busy_i,
  input logic             res_valid_i,
  input logic             ready_irq_o,
  input logic             cmp_flag_o,
  input logic             cmp_en,
  input logic             cmp_mode,
  input logic             cmp_dec,
  input logic             flag_clr,
  input logic [RES_W-1:0] thr,
  input logic [CNT_W-1:0] cnt
);
  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_addr_i == 2'd1) |-> (cfg_rdata_o[4:2] == 3'b000)); // R2

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_we_i && conv_busy_i && (cfg_addr_i <= 2'd1)) |=>
      (thr == $past(thr) && cmp_en == $past(cmp_en) &&
       cmp_mode == $past(cmp_mode) && cmp_dec == $past(cmp_dec))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmp_en && !res_valid_i) |=> (cnt == $past(cnt))); // R6

  AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cmp_flag_o) |-> (cnt == '0)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmp_flag_o && !flag_clr) |=> cmp_flag_o); // R9

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    !cmp_en |=> (cnt == '0)); // R10

  AST_READY_MASKED: assert property (@(posedge clk) disable iff (!rst_sn)
    cmp_en |-> !ready_irq_o); // R11
endmodule

bind conv_threshold_filter ctf_checker #(.RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .conv_busy_i (conv_busy_i),
  .res_valid_i (res_valid_i),
  .ready_irq_o (ready_irq_o),
  .cmp_flag_o  (cmp_flag_o),
  .cmp_en      (cmp_en),
  .cmp_mode    (cmp_mode),
  .cmp_dec     (cmp_dec),
  .flag_clr    (flag_clr),
  .thr         (thr),
  .cnt         (cnt)
);

// File: tb/conv_threshold_filter_test.sv
`timescale 1ns/1ps
module conv_threshold_filter_test;
  localparam int RES_W = 10;
  localparam int CNT_W = 8;
  localparam int FULL  = 1 << RES_W;
  localparam int HALF  = 1 << (RES_W - 1);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             we;
  logic [1:0]       addr;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic             busy;
  logic [1:0]       kind;
  logic             sign;
  logic             valid;
  logic [RES_W-1:0] res;
  logic             rdy_in;
  logic             rdy_out;
  logic             flag;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_cnt, m_thr, m_tgt;
  bit m_en, m_mode, m_dec, m_flag;

  always #5 clk = ~clk;

  conv_threshold_filter #(.RES_W(RES_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .conv_busy_i(busy),
    .conv_kind_i(kind), .res_sign_i(sign), .res_valid_i(valid),
    .res_data_i(res), .conv_done_flag_i(rdy_in), .ready_irq_o(rdy_out),
    .cmp_flag_o(flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    @(negedge clk);
    addr = a;
    #2;
    chk(req, int'(rdata), exp);
  endtask

  task automatic set_cfg(input bit en, input bit md, input bit dc, input int th);
    wr(2'd0, 8'(th));
    wr(2'd1, {en, md, dc, 3'b000, 2'(th >> 8)});
    m_en = en; m_mode = md; m_dec = dc; m_thr = th;
    if (!en) m_cnt = 0;
  endtask

  task automatic set_tgt(input int t);
    wr(2'd2, 8'(t));
    m_tgt = t;
  endtask

  function automatic bit exp_hit(input int r);
    int sv, tv;
    sv = r; tv = m_thr;
    if (kind == 2'd1 && sign) begin
      if (sv >= HALF) sv = sv - FULL;
      if (tv >= HALF) tv = tv - FULL;
    end
    return m_mode ? (sv < tv) : (sv >= tv);
  endfunction

  // One result strobe, optionally with a flag clear on the same edge.
  task automatic conv(input int r, input bit clr);
    int nx;
    bit fire;
    @(negedge clk);
    valid = 1'b1; res = RES_W'(r);
    if (clr) begin we = 1'b1; addr = 2'd3; wdata = 8'h01; end
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
    fire = 0;
    if (!m_en) m_cnt = 0;
    else begin
      if (exp_hit(r)) nx = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      else if (m_dec) nx = (m_cnt == 0) ? 0 : m_cnt - 1;
      else nx = 0;
      if (m_tgt != 0 && nx == m_tgt) begin fire = 1; nx = 0; end
      m_cnt = nx;
    end
    m_flag = fire ? 1'b1 : (clr ? 1'b0 : m_flag);
  endtask

  task automatic clear_flag();
    wr(2'd3, 8'h01);
    m_flag = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int seed;
    int r;
    rst_n = 1'b0; we = 0; addr = 0; wdata = 0; busy = 0; kind = 0; sign = 0;
    valid = 0; res = '0; rdy_in = 0;
    m_cnt = 0; m_thr = 0; m_tgt = 0; m_en = 0; m_mode = 0; m_dec = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1 thr_lo", 2'd0, 0);
    rd_chk("R1 ctrl", 2'd1, 0);
    rd_chk("R1 target", 2'd2, 0);
    rd_chk("R1 status", 2'd3, 0);
    chk("R1 flag", int'(flag), 0);

    // R11 / R10: disabled passes ready flag
    rdy_in = 1'b1; #1;
    chk("R11 pass when disabled", int'(rdy_out), 1);

    // R2 layout, unimplemented bits read 0
    wr(2'd1, 8'hFF);
    rd_chk("R2 ctrl unimplemented", 2'd1, 8'hE3);
    wr(2'd0, 8'hA5);
    rd_chk("R2 thr_lo", 2'd0, 8'hA5);
    wr(2'd2, 8'h9C);
    rd_chk("R2 target", 2'd2, 8'h9C);
    @(negedge clk); #1;
    chk("R11 masked when enabled", int'(rdy_out), 0);
    rdy_in = 1'b0; #1;
    chk("R11 masked low", int'(rdy_out), 0);
    wr(2'd1, 8'h00); rdy_in = 1'b1; #1;
    chk("R11 pass again", int'(rdy_out), 1);
    rdy_in = 1'b0;

    // R3 write lock
    busy = 1'b1;
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'hE2);
    wr(2'd2, 8'h11);
    rd_chk("R3 thr_lo locked", 2'd0, 8'hA5);
    rd_chk("R3 ctrl locked", 2'd1, 8'h00);
    rd_chk("R3 target open", 2'd2, 8'h11);
    busy = 1'b0;
    wr(2'd0, 8'h3C);
    rd_chk("R3 thr_lo after busy", 2'd0, 8'h3C);

    // R4 R5 exhaustive sweep, target 1 makes each compare a flag
    set_tgt(1);
    for (int md = 0; md < 2; md++) begin
      for (int ks = 0; ks < 4; ks++) begin
        for (int ti = 0; ti < 3; ti++) begin
          int th;
          th = (ti == 0) ? 16 : ((ti == 1) ? 512 : 1008);
          case (ks)
            0: begin kind = 2'd0; sign = 1'b1; end
            1: begin kind = 2'd1; sign = 1'b0; end
            2: begin kind = 2'd1; sign = 1'b1; end
            default: begin kind = 2'd2; sign = 1'b1; end
          endcase
          set_cfg(1'b1, md[0], 1'b0, th);
          for (int v = 0; v < FULL; v++) begin
            conv(v, m_flag);
            chk("R4 R5 compare sweep", int'(flag), int'(m_flag));
          end
          if (m_flag) clear_flag();
        end
      end
    end
    kind = 2'd3; sign = 1'b1;
    set_cfg(1'b1, 1'b0, 1'b0, 1008);
    conv(5, 1'b0);
    chk("R5 reserved kind unsigned", int'(flag), 0);

    // R6 R7 R8 filter sequences
    kind = 2'd0; sign = 1'b0;
    set_tgt(5);
    seed = 7;
    for (int pass = 0; pass < 2; pass++) begin
      set_cfg(1'b1, 1'b0, pass == 0, 512);
      for (int i = 0; i < 2000; i++) begin
        seed = seed * 1103515245 + 12345;
        r = (seed >>> 16) & (FULL - 1);
        conv(r, m_flag);
        chk(pass == 0 ? "R7 R8 decrement stream" : "R7 R8 clear stream",
            int'(flag), int'(m_flag));
      end
    end
    if (m_flag) clear_flag();

    // R8 exact count then restart
    set_cfg(1'b0, 1'b0, 1'b1, 512);
    set_cfg(1'b1, 1'b0, 1'b1, 512);
    set_tgt(3);
    conv(600, 0); conv(600, 0);
    chk("R8 below target", int'(flag), 0);
    conv(600, 0);
    chk("R8 at target", int'(flag), 1);
    clear_flag();
    conv(600, 0); conv(600, 0);
    chk("R8 restarted from zero", int'(flag), 0);

    // R6 saturation at 255, then lowered target reached by decrement
    set_tgt(0);
    for (int i = 0; i < 300; i++) conv(900, 0);
    chk("R8 target zero never fires", int'(flag), 0);
    set_tgt(250);
    for (int i = 0; i < 4; i++) conv(10, 0);
    chk("R6 saturated count 251", int'(flag), 0);
    conv(10, 0);
    chk("R6 saturation then reach 250", int'(flag), 1);

    // R9 sticky flag and clear priority
    repeat (5) @(negedge clk);
    chk("R9 sticky idle", int'(flag), 1);
    wr(2'd3, 8'hFE);
    chk("R9 write 0 keeps", int'(flag), 1);
    rd_chk("R9 status read", 2'd3, 1);
    clear_flag();
    chk("R9 w1c clears", int'(flag), 0);
    set_tgt(1);
    conv(900, 0);
    chk("R9 fire", int'(flag), 1);
    conv(900, 1);
    chk("R9 set beats clear", int'(flag), 1);
    clear_flag();

    // R10 disabled holds counter at zero
    set_tgt(3);
    conv(900, 0); conv(900, 0);
    set_cfg(1'b0, 1'b0, 1'b1, 512);
    conv(900, 0); conv(900, 0);
    chk("R10 no flag disabled", int'(flag), 0);
    set_cfg(1'b1, 1'b0, 1'b1, 512);
    conv(900, 0); conv(900, 0);
    chk("R10 counter was cleared", int'(flag), 0);
    conv(900, 0);
    chk("R10 counts from zero", int'(flag), 1);

    // R6 no valid strobe means no count
    clear_flag();
    conv(900, 0); conv(900, 0);
    repeat (10) @(negedge clk);
    chk("R6 hold without valid", int'(flag), 0);
    conv(900, 0);
    chk("R6 resume", int'(flag), 1);

    finish_run();
  end
endmodule